// File: doc/BRIEF.md
# Address-Triggered Load/Store Unit

This block is the memory side of a register-file datapath in which software never issues an explicit load or store. It keeps a file of address registers and a file of wide data registers. Writing an address register may also start a memory access, depending on which register is written. Some indices start a load into the data register with the same index. Other indices start a store of the data register with the same index. Index zero only holds an address. The written value is a base plus a displacement, computed inside the block.

Requests leave through a one-cycle-per-request port to a word-addressed memory. The memory is interleaved across banks that are picked by the low address bits. A bank that accepts a request stays busy for a fixed number of cycles. An address write that would reach a busy bank is held back through a ready signal. Several loads can be outstanding at once. Each one is tracked by a per-register pending flag, which consumers may watch before they use the data. Load data comes back with the destination index as a tag and is written into the data register file.

Top module: `addr_trig_lsu`

## Requirements
- R1: After reset all address and data registers read zero, no load is pending, no memory request is valid, and the write port reports ready.
- R2: An accepted address write stores (base + displacement) modulo 2^18 into the indexed address register. The memory address sent with any request is the low 17 bits of that sum.
- R3: A write to address register 0 updates only that register. It never stalls and never produces a memory request.
- R4: An accepted write to address register 1 to 5 produces, one cycle later, a single-cycle request with the write flag 0 and the tag equal to the index, and it sets that register's pending flag.
- R5: An accepted write to address register 6 or 7 produces, one cycle later, a request with the write flag 1 and the tag equal to the index. Its data is the value the same-index data register held in the write cycle. A data-port write to that register in the same cycle is not seen by the store.
- R6: A load response writes its data into the data register named by its tag and clears that register's pending flag. Both changes are visible in the next cycle.
- R7: When a load response and a data-port write target the same data register in the same cycle, the response data is kept.
- R8: The bank is the low 5 bits of the memory address. Once a bank accepts a request, it accepts no other request until BANK_BUSY cycles later (4 by default). While blocked, the address write sees ready low and changes no register.
- R9: A load write to an address register whose pending flag is set is held with ready low, and the register is left unchanged, until the response clears the flag.
- R10: Accesses to distinct free banks are accepted on consecutive cycles, so several loads are outstanding at once.
- R11: A data-port write with its valid high updates the indexed data register, and the new value can be read back in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Address register write request |
| wrIdx | input | 3 | Address register index |
| wrBase | input | 18 | Base operand of the written address |
| wrDisp | input | 18 | Displacement operand of the written address |
| wrReady | output | 1 | Low when the pending address write is held |
| xWrValid | input | 1 | Data register write from the execution units |
| xWrIdx | input | 3 | Data register index for that write |
| xWrData | input | 60 | Data register write value |
| aRdIdx | input | 3 | Address register read index |
| aRdData | output | 18 | Address register read value |
| xRdIdx | input | 3 | Data register read index |
| xRdData | output | 60 | Data register read value |
| loadPending | output | 8 | One pending-load flag per data register |
| memReqValid | output | 1 | Memory request valid, one cycle per request |
| memReqWrite | output | 1 | 1 for a store, 0 for a load |
| memReqAddr | output | 17 | Word address (bank in bits 4:0) |
| memReqData | output | 60 | Store data |
| memReqTag | output | 3 | Register index carried by the request |
| memRspValid | input | 1 | Load response valid |
| memRspTag | input | 3 | Destination data register of the response |
| memRspData | input | 60 | Load response data |

## Verification
Two pairs of functions can meet in one cycle. A store launch can coincide with an execution-unit write to the register being stored, and a load response can coincide with an execution-unit write to the register it fills. The bench provokes the first by raising the data-port write in the same cycle as the store's address write. The scoreboard then expects the store request to carry the old value, while a later readback must show the new one. It provokes the second by driving the response and the data-port write to one index together, and it expects the response value on readback. Bank stalls are counted cycle by cycle against the busy window after a same-bank load.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  // Strobes from the control path to the datapath for one write-port cycle.
  typedef struct packed {
    logic addrWe;   // commit the effective address into the address register
    logic issue;    // launch a memory request this cycle
    logic isStore;  // the launched request is a store
  } lsuStrobeT;

endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int BANK_W    = 5,
  parameter int BANK_BUSY = 4,
  parameter int LOAD_LO   = 1,
  parameter int LOAD_HI   = 5,
  parameter int STORE_LO  = 6,
  parameter int STORE_HI  = 7,
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [BANK_W-1:0] effBank,
  input  logic              rspValid,
  input  logic [IDX_W-1:0]  rspTag,
  output logic              wrReady,
  output lsuStrobeT         strb,
  output logic [NREG-1:0]   loadPending
);

  localparam int NBANK = 1 << BANK_W;
  localparam int CNT_W = $clog2(BANK_BUSY + 1);
  localparam logic [CNT_W-1:0] BUSY_INIT = CNT_W'(BANK_BUSY - 1);
  localparam logic [IDX_W-1:0] LD_LO = IDX_W'(LOAD_LO);
  localparam logic [IDX_W-1:0] LD_HI = IDX_W'(LOAD_HI);
  localparam logic [IDX_W-1:0] ST_LO = IDX_W'(STORE_LO);
  localparam logic [IDX_W-1:0] ST_HI = IDX_W'(STORE_HI);

  logic [CNT_W-1:0] bankCnt [NBANK];
  logic [NBANK-1:0] bankBusy;
  logic [NREG-1:0]  pendQ;
  logic isLoad, isStore, isMem, stall, accept, launchLoad;

  always_comb begin
    for (int b = 0; b < NBANK; b++) bankBusy[b] = (bankCnt[b] != '0);
  end

  assign isLoad     = (wrIdx >= LD_LO) && (wrIdx <= LD_HI);
  assign isStore    = (wrIdx >= ST_LO) && (wrIdx <= ST_HI);
  assign isMem      = isLoad || isStore;
  assign stall      = wrValid && ((isMem && bankBusy[effBank]) ||
                                  (isLoad && pendQ[wrIdx]));
  assign accept     = wrValid && !stall;
  assign launchLoad = accept && isLoad;
  assign wrReady    = !stall;

  assign strb.addrWe  = accept;
  assign strb.issue   = accept && isMem;
  assign strb.isStore = isStore;
  assign loadPending  = pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      for (int b = 0; b < NBANK; b++) bankCnt[b] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (launchLoad && wrIdx == IDX_W'(i))
          pendQ[i] <= 1'b1;
        else if (rspValid && rspTag == IDX_W'(i))
          pendQ[i] <= 1'b0;
      end
      for (int b = 0; b < NBANK; b++) begin
        if (strb.issue && effBank == BANK_W'(b))
          bankCnt[b] <= BUSY_INIT;
        else if (bankCnt[b] != '0)
          bankCnt[b] <= bankCnt[b] - 1'b1;
      end
    end
  end

  // R4: a launched load leaves its pending flag set in the next cycle.
  a_r4_pend_set: assert property (@(posedge clk) disable iff (!rstN)
    launchLoad |=> loadPending[$past(wrIdx)]);

  // R6: a response clears the flag of its tag unless a new load claims it.
  a_r6_pend_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !(launchLoad && wrIdx == rspTag)) |=> !loadPending[$past(rspTag)]);

endmodule

// File: rtl/lsu_dpath.sv
module lsu_dpath
  import lsu_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int AW        = 18,
  parameter int DW        = 60,
  parameter int MEM_AW    = 17,
  parameter int BANK_W    = 5,
  parameter int BANK_BUSY = 4,
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsuStrobeT         strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [AW-1:0]     wrBase,
  input  logic [AW-1:0]     wrDisp,
  output logic [BANK_W-1:0] effBank,
  input  logic              xWrValid,
  input  logic [IDX_W-1:0]  xWrIdx,
  input  logic [DW-1:0]     xWrData,
  input  logic [IDX_W-1:0]  aRdIdx,
  output logic [AW-1:0]     aRdData,
  input  logic [IDX_W-1:0]  xRdIdx,
  output logic [DW-1:0]     xRdData,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [MEM_AW-1:0] memReqAddr,
  output logic [DW-1:0]     memReqData,
  output logic [IDX_W-1:0]  memReqTag,
  input  logic              rspValid,
  input  logic [IDX_W-1:0]  rspTag,
  input  logic [DW-1:0]     rspData
);

  logic [AW-1:0] aRegs [NREG];
  logic [DW-1:0] xRegs [NREG];
  logic [AW-1:0] effAddr;

  assign effAddr = wrBase + wrDisp;
  assign effBank = effAddr[BANK_W-1:0];
  assign aRdData = aRegs[aRdIdx];
  assign xRdData = xRegs[xRdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) aRegs[i] <= '0;
    end else if (strb.addrWe) begin
      aRegs[wrIdx] <= effAddr;
    end
  end

  // Response has priority over the execution-unit port on the same register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) xRegs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (rspValid && rspTag == IDX_W'(i))
          xRegs[i] <= rspData;
        else if (xWrValid && xWrIdx == IDX_W'(i))
          xRegs[i] <= xWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReqValid <= 1'b0;
      memReqWrite <= 1'b0;
      memReqAddr  <= '0;
      memReqData  <= '0;
      memReqTag   <= '0;
    end else begin
      memReqValid <= strb.issue;
      if (strb.issue) begin
        memReqWrite <= strb.isStore;
        memReqAddr  <= effAddr[MEM_AW-1:0];
        memReqData  <= strb.isStore ? xRegs[wrIdx] : '0;
        memReqTag   <= wrIdx;
      end
    end
  end

  // R3: register 0 never shows up as a request tag.
  a_r3_no_req_reg0: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqTag != '0));

  generate
    if (BANK_BUSY > 1) begin : g_gap
      // R8: back-to-back requests never hit the same bank.
      a_r8_bank_gap: assert property (@(posedge clk) disable iff (!rstN)
        (memReqValid && $past(memReqValid)) |->
          (memReqAddr[BANK_W-1:0] != $past(memReqAddr[BANK_W-1:0])));
    end
  endgenerate

endmodule

// File: rtl/addr_trig_lsu.sv
module addr_trig_lsu
  import lsu_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int AW        = 18,
  parameter int DW        = 60,
  parameter int MEM_AW    = 17,
  parameter int BANK_W    = 5,
  parameter int BANK_BUSY = 4,
  parameter int LOAD_LO   = 1,
  parameter int LOAD_HI   = 5,
  parameter int STORE_LO  = 6,
  parameter int STORE_HI  = 7,
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [AW-1:0]     wrBase,
  input  logic [AW-1:0]     wrDisp,
  output logic              wrReady,
  input  logic              xWrValid,
  input  logic [IDX_W-1:0]  xWrIdx,
  input  logic [DW-1:0]     xWrData,
  input  logic [IDX_W-1:0]  aRdIdx,
  output logic [AW-1:0]     aRdData,
  input  logic [IDX_W-1:0]  xRdIdx,
  output logic [DW-1:0]     xRdData,
  output logic [NREG-1:0]   loadPending,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [MEM_AW-1:0] memReqAddr,
  output logic [DW-1:0]     memReqData,
  output logic [IDX_W-1:0]  memReqTag,
  input  logic              memRspValid,
  input  logic [IDX_W-1:0]  memRspTag,
  input  logic [DW-1:0]     memRspData
);

  lsuStrobeT         strb;
  logic [BANK_W-1:0] effBank;

  lsu_ctrl #(
    .NREG(NREG), .BANK_W(BANK_W), .BANK_BUSY(BANK_BUSY),
    .LOAD_LO(LOAD_LO), .LOAD_HI(LOAD_HI),
    .STORE_LO(STORE_LO), .STORE_HI(STORE_HI)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrIdx(wrIdx), .effBank(effBank),
    .rspValid(memRspValid), .rspTag(memRspTag),
    .wrReady(wrReady), .strb(strb), .loadPending(loadPending)
  );

  lsu_dpath #(
    .NREG(NREG), .AW(AW), .DW(DW), .MEM_AW(MEM_AW),
    .BANK_W(BANK_W), .BANK_BUSY(BANK_BUSY)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrIdx(wrIdx), .wrBase(wrBase), .wrDisp(wrDisp), .effBank(effBank),
    .xWrValid(xWrValid), .xWrIdx(xWrIdx), .xWrData(xWrData),
    .aRdIdx(aRdIdx), .aRdData(aRdData), .xRdIdx(xRdIdx), .xRdData(xRdData),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memReqTag(memReqTag),
    .rspValid(memRspValid), .rspTag(memRspTag), .rspData(memRspData)
  );

endmodule

// File: tb/test_addr_trig_lsu.sv
module test_addr_trig_lsu;

  localparam int PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [16:0] addr;
    logic [59:0] data;
    logic [2:0]  tag;
  } reqT;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 1'b0;  logic [2:0] wrIdx = '0;
  logic [17:0] wrBase = '0, wrDisp = '0;
  logic wrReady;
  logic xWrValid = 1'b0; logic [2:0] xWrIdx = '0; logic [59:0] xWrData = '0;
  logic [2:0] aRdIdx = '0, xRdIdx = '0;
  logic [17:0] aRdData; logic [59:0] xRdData;
  logic [7:0] loadPending;
  logic memReqValid, memReqWrite; logic [16:0] memReqAddr;
  logic [59:0] memReqData; logic [2:0] memReqTag;
  logic memRspValid = 1'b0; logic [2:0] memRspTag = '0; logic [59:0] memRspData = '0;

  int checks = 0, failures = 0;
  reqT expQ[$];
  logic [59:0] xModel [8];
  logic [7:0]  pendModel = '0;

  always #(PERIOD/2) clk = ~clk;

  addr_trig_lsu i_addr_trig_lsu (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrIdx(wrIdx), .wrBase(wrBase),
    .wrDisp(wrDisp), .wrReady(wrReady), .xWrValid(xWrValid), .xWrIdx(xWrIdx),
    .xWrData(xWrData), .aRdIdx(aRdIdx), .aRdData(aRdData), .xRdIdx(xRdIdx),
    .xRdData(xRdData), .loadPending(loadPending), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqData(memReqData),
    .memReqTag(memReqTag), .memRspValid(memRspValid), .memRspTag(memRspTag),
    .memRspData(memRspData));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected request for every request seen.
  always @(negedge clk) begin
    if (rstN) begin
      if (memReqValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected request", 64'(memReqTag), 64'hF);
        end else begin
          reqT e;
          e = expQ.pop_front();
          check(memReqWrite == e.wr, "R4/R5 request kind", 64'(memReqWrite), 64'(e.wr));
          check(memReqAddr == e.addr, "R2 request address", 64'(memReqAddr), 64'(e.addr));
          check(memReqTag == e.tag, "R4/R5 request tag", 64'(memReqTag), 64'(e.tag));
          if (e.wr)
            check(memReqData == e.data, "R5 store data", 64'(memReqData), 64'(e.data));
        end
      end else if (expQ.size() != 0) begin
        check(1'b0, "R10 missing request", 64'(expQ.size()), 64'h0);
      end
    end
  end

  function automatic bit isLd(input logic [2:0] i); return i >= 1 && i <= 5; endfunction
  function automatic bit isSt(input logic [2:0] i); return i >= 6; endfunction

  task automatic pushExp(input logic [2:0] idx, input logic [17:0] eff);
    reqT e;
    e.wr = isSt(idx); e.addr = eff[16:0]; e.tag = idx;
    e.data = isSt(idx) ? xModel[idx] : '0;
    if (isLd(idx) || isSt(idx)) expQ.push_back(e);
    if (isLd(idx)) pendModel[idx] = 1'b1;
  endtask

  // Presents an address write for one cycle; called just after a rising edge.
  task automatic addrWrite(input logic [2:0] idx, input logic [17:0] base,
                           input logic [17:0] disp, input bit expReady, input string req);
    logic rdy;
    wrValid = 1'b1; wrIdx = idx; wrBase = base; wrDisp = disp;
    @(negedge clk); rdy = wrReady;
    check(rdy == expReady, req, 64'(rdy), 64'(expReady));
    @(posedge clk); #1;
    wrValid = 1'b0; xWrValid = 1'b0;
    if (rdy) pushExp(idx, base + disp);
  endtask

  task automatic addrWriteWait(input logic [2:0] idx, input logic [17:0] base,
                               input logic [17:0] disp, output int stalls);
    logic rdy;
    stalls = 0;
    wrValid = 1'b1; wrIdx = idx; wrBase = base; wrDisp = disp;
    do begin
      @(negedge clk); rdy = wrReady;
      if (!rdy) stalls++;
      @(posedge clk); #1;
    end while (!rdy && stalls < 50);
    wrValid = 1'b0;
    pushExp(idx, base + disp);
  endtask

  task automatic dataWrite(input logic [2:0] idx, input logic [59:0] d);
    xWrValid = 1'b1; xWrIdx = idx; xWrData = d;
    @(posedge clk); #1; xWrValid = 1'b0;
    xModel[idx] = d;
  endtask

  task automatic respond(input logic [2:0] tag, input logic [59:0] d);
    memRspValid = 1'b1; memRspTag = tag; memRspData = d;
    @(posedge clk); #1; memRspValid = 1'b0; xWrValid = 1'b0;
    xModel[tag] = d; pendModel[tag] = 1'b0;
  endtask

  task automatic checkA(input logic [2:0] idx, input logic [17:0] exp, input string req);
    aRdIdx = idx; @(negedge clk);
    check(aRdData == exp, req, 64'(aRdData), 64'(exp));
    @(posedge clk); #1;
  endtask

  task automatic checkX(input logic [2:0] idx, input logic [59:0] exp, input string req);
    xRdIdx = idx; @(negedge clk);
    check(xRdData == exp, req, 64'(xRdData), 64'(exp));
    @(posedge clk); #1;
  endtask

  task automatic checkPend(input string req);
    @(negedge clk);
    check(loadPending == pendModel, req, 64'(loadPending), 64'(pendModel));
    @(posedge clk); #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    check(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int st;
    for (int i = 0; i < 8; i++) xModel[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(wrReady == 1'b1 && memReqValid == 1'b0, "R1 ready/request", 64'({wrReady, memReqValid}), 64'h2);
    check(loadPending == '0, "R1 pending", 64'(loadPending), 64'h0);
    check(aRdData == '0 && xRdData == '0, "R1 registers", 64'(aRdData), 64'h0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R11: data-port writes
    dataWrite(3'd6, 60'hA5A_0000_1234_5666);
    dataWrite(3'd7, 60'h777_7777_0000_0007);
    checkX(3'd6, 60'hA5A_0000_1234_5666, "R11 data write x6");

    // R3, R2: register 0 only holds the sum
    addrWrite(3'd0, 18'd100, 18'd5, 1'b1, "R3 ready for reg0");
    checkA(3'd0, 18'd105, "R3 reg0 value");
    addrWrite(3'd0, 18'h3FFFF, 18'd2, 1'b1, "R2 ready wrap");
    checkA(3'd0, 18'd1, "R2 wrap modulo 2^18");

    // R4, R10: two loads to distinct banks on consecutive cycles
    addrWrite(3'd1, 18'h40, 18'd3, 1'b1, "R4 load a1 bank 3");
    addrWrite(3'd2, 18'h44, 18'd0, 1'b1, "R10 back-to-back bank 4");
    // R8: same bank 3 again, two stall cycles before acceptance
    addrWriteWait(3'd3, 18'h63, 18'd0, st);
    check(st == 2, "R8 bank busy stall count", 64'(st), 64'd2);
    checkPend("R4 pending flags 1,2,3");

    // R9: load on a pending register is held and changes nothing
    addrWrite(3'd1, 18'h50, 18'd0, 1'b0, "R9 stall on pending reg1");
    checkA(3'd1, 18'h43, "R9 a1 unchanged");
    checkPend("R9 pending unchanged");

    // R6: response fills data and clears the flag
    respond(3'd1, 60'h111_2222_3333_4444);
    checkX(3'd1, 60'h111_2222_3333_4444, "R6 load data x1");
    checkPend("R6 flag cleared");
    addrWrite(3'd1, 18'h50, 18'd0, 1'b1, "R9 accepted after clear");

    // R5: store with same-cycle data-port write to x6 (bank 0, wrapped sum)
    xWrValid = 1'b1; xWrIdx = 3'd6; xWrData = 60'hBEE_F000_0000_0006;
    addrWrite(3'd6, 18'h3FFFF, 18'h21, 1'b1, "R5 store a6 accepted");
    xModel[6] = 60'hBEE_F000_0000_0006;
    checkX(3'd6, 60'hBEE_F000_0000_0006, "R5 x6 new value after store");
    checkA(3'd6, 18'h20, "R2 a6 wrapped address");

    // R2: bit 17 of the sum is dropped on the memory address
    addrWrite(3'd7, 18'h20000, 18'd5, 1'b1, "R5 store a7 accepted");

    // R7: response and data-port write on x2 in the same cycle
    xWrValid = 1'b1; xWrIdx = 3'd2; xWrData = 60'hDEAD;
    respond(3'd2, 60'h222_0000_0000_0002);
    checkX(3'd2, 60'h222_0000_0000_0002, "R7 response wins");

    respond(3'd3, 60'h333);
    respond(3'd1, 60'h444);
    checkX(3'd3, 60'h333, "R6 load data x3");
    checkPend("R6 all flags clear");
    check(loadPending == '0, "R6 no pending at end", 64'(loadPending), 64'h0);

    repeat (3) @(posedge clk);
    check(expQ.size() == 0, "R4 all requests observed", 64'(expQ.size()), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule